// File: doc/BRIEF.md
# Load-adaptive valley-count selector

This block holds the valley number, from 1 to 7, that a quasi-resonant flyback controller waits for before each turn-on of the power switch. A low number gives high switching frequency for heavy load. A high number stretches the off-time for light load. The block watches the feedback comparators over a long counting window. When the window closes, it raises the number, keeps it, or lowers it, depending on how high the feedback reached during that window.

The comparators sit outside the block. Two threshold sets exist, one for each mains range. Each set supplies an "above low" flag and an "above high" flag, and a line-range input picks which set counts. A separate reset comparator flags a sudden load step. That flag, a start-up pulse and a burst-exit pulse each force the number to 1 at once and restart the window. Comparator flags are sampled on a slow enable tick. With a 1 MHz tick, the default window of 48000 ticks spans 48 ms.

Top module: `valley_target_sel`

## Requirements
- R1: After reset the target output is 1.
- R2: The target changes only on the last tick of a window of WINDOW_TICKS enable ticks, or on a force event; clock cycles without a tick neither advance the window nor sample the flags.
- R3: If no selected "above low" or "above high" flag was seen on any tick of the window, the target rises by 1 at the window end and saturates at 7.
- R4: If a selected "above low" flag (bit 0 of a flag pair) was seen but no selected "above high" flag, the target is held at the window end.
- R5: If a selected "above high" flag (bit 1 of a flag pair) was seen on any tick of the window, the target falls by 1 at the window end and saturates at 1.
- R6: An asserted reset-comparator input sets the target to 1 on the next clock edge, with or without a tick, and restarts the window at its first tick.
- R7: A start-up pulse or a burst-exit pulse sets the target to 1 on the next clock edge and restarts the window.
- R8: With lineHigh at 0 only the flag pair flagsLoLine counts; with lineHigh at 1 only flagsHiLine counts; the unselected pair has no effect.
- R9: A flag seen on a single tick, including the window's last tick, counts for the whole window, and what was seen in one window is not carried into the next.
- R10: The target always lies within 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Slow sampling tick that advances the window |
| lineHigh | input | 1 | 1 selects the high-line threshold set |
| flagsLoLine | input | 2 | Low-line set: bit 0 above low, bit 1 above high |
| flagsHiLine | input | 2 | High-line set: bit 0 above low, bit 1 above high |
| overReset | input | 1 | Feedback above the reset threshold |
| startPulse | input | 1 | Start-up event |
| burstExit | input | 1 | Leaving burst mode |
| valleyTarget | output | 3 | Target valley number, 1 to 7 |

## Verification
A table of windows drives the target up, holds it and drives it down. Each row places a single-tick flag at a chosen position, so an early hit, a last-tick hit and an empty window that follows a busy one can be told apart. Rows swap which threshold set carries the flag under each lineHigh value. This shows that the unselected pair is ignored while the selected one acts. Directed cases hold the target at each saturation end, stop one tick short of a window end, and fire each force input mid-window to confirm the immediate 1 and the restart of the window.

// File: rtl/valley_sel_pkg.sv
package valley_sel_pkg;
  localparam int VAL_W   = 3;
  localparam int VAL_MIN = 1;
  localparam int VAL_MAX = 7;

  // Strobes from window control to the target datapath.
  typedef struct packed {
    logic force1;
    logic stepUp;
    logic stepDown;
  } valley_strb_t;
endpackage

// File: rtl/valley_win_ctrl.sv
module valley_win_ctrl
  import valley_sel_pkg::*;
#(
  parameter int WINDOW_TICKS = 48000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         lineHigh,
  input  logic [1:0]   flagsLoLine,
  input  logic [1:0]   flagsHiLine,
  input  logic         overReset,
  input  logic         startPulse,
  input  logic         burstExit,
  output valley_strb_t strb
);
  localparam int CNT_W = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_TICKS - 1);

  logic [CNT_W-1:0] winCnt;
  logic stickyLow, stickyHigh;
  logic [1:0] selFlags;
  logic forceNow, lastTick, seenLow, seenHigh;

  // The line-range input picks the active threshold pair.
  assign selFlags = lineHigh ? flagsHiLine : flagsLoLine;
  assign forceNow = overReset | startPulse | burstExit;
  assign lastTick = tickEn && (winCnt == LAST_CNT);
  assign seenLow  = stickyLow  | (tickEn & selFlags[0]);
  assign seenHigh = stickyHigh | (tickEn & selFlags[1]);

  always_comb begin
    strb          = '0;
    strb.force1   = forceNow;
    if (!forceNow && lastTick) begin
      if (seenHigh)      strb.stepDown = 1'b1;
      else if (!seenLow) strb.stepUp   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt     <= '0;
      stickyLow  <= 1'b0;
      stickyHigh <= 1'b0;
    end else if (forceNow || lastTick) begin
      winCnt     <= '0;
      stickyLow  <= 1'b0;
      stickyHigh <= 1'b0;
    end else if (tickEn) begin
      winCnt     <= winCnt + CNT_W'(1);
      stickyLow  <= seenLow;
      stickyHigh <= seenHigh;
    end
  end

  // R6 / R7: any force event restarts the window.
  p_force_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    forceNow |=> (winCnt == '0 && !stickyLow && !stickyHigh));

  // R2: no tick, no movement of the window.
  p_idle_no_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !forceNow) |=> $stable(winCnt));

  // R2: at most one strobe per cycle.
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.force1, strb.stepUp, strb.stepDown}));

  // R9: a window end leaves no stale sticky state.
  p_sticky_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    lastTick |=> (!stickyLow && !stickyHigh));
endmodule

// File: rtl/valley_target_dp.sv
module valley_target_dp
  import valley_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  valley_strb_t     strb,
  output logic [VAL_W-1:0] target
);
  localparam logic [VAL_W-1:0] MIN_V = VAL_W'(VAL_MIN);
  localparam logic [VAL_W-1:0] MAX_V = VAL_W'(VAL_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              target <= MIN_V;
    else if (strb.force1)                   target <= MIN_V;
    else if (strb.stepUp && target < MAX_V) target <= target + VAL_W'(1);
    else if (strb.stepDown && target > MIN_V) target <= target - VAL_W'(1);
  end

  p_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (target >= MIN_V && target <= MAX_V));

  p_force_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.force1 |=> (target == MIN_V));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp && !strb.force1 && target < MAX_V) |=> (target == $past(target) + VAL_W'(1)));

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepDown && !strb.force1 && target > MIN_V) |=> (target == $past(target) - VAL_W'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.force1 && !strb.stepUp && !strb.stepDown) |=> $stable(target));
endmodule

// File: rtl/valley_target_sel.sv
module valley_target_sel
  import valley_sel_pkg::*;
#(
  parameter int WINDOW_TICKS = 48000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       lineHigh,
  input  logic [1:0] flagsLoLine,
  input  logic [1:0] flagsHiLine,
  input  logic       overReset,
  input  logic       startPulse,
  input  logic       burstExit,
  output logic [2:0] valleyTarget
);
  valley_strb_t strb;

  valley_win_ctrl #(.WINDOW_TICKS(WINDOW_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineHigh(lineHigh),
    .flagsLoLine(flagsLoLine), .flagsHiLine(flagsHiLine),
    .overReset(overReset), .startPulse(startPulse), .burstExit(burstExit),
    .strb(strb)
  );

  valley_target_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .target(valleyTarget)
  );
endmodule

// File: tb/sim_valley_target_sel.sv
module sim_valley_target_sel;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, lineHigh = 1'b0;
  logic [1:0] flagsLoLine = '0, flagsHiLine = '0;
  logic overReset = 1'b0, startPulse = 1'b0, burstExit = 1'b0;
  logic [2:0] valleyTarget;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  valley_target_sel #(.WINDOW_TICKS(WIN)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineHigh(lineHigh),
    .flagsLoLine(flagsLoLine), .flagsHiLine(flagsHiLine),
    .overReset(overReset), .startPulse(startPulse), .burstExit(burstExit),
    .valleyTarget(valleyTarget)
  );

  // Row: [11] lineHigh, [10:9] low-line pair, [8:7] high-line pair,
  // [6:4] tick position of the one-tick flag, [2:0] expected target.
  localparam int NROWS = 22;
  localparam logic [11:0] ROWS [NROWS] = '{
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd2},  // R3 empty window
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd3},
    {1'b1, 2'b00, 2'b00, 3'd0, 1'b0, 3'd4},
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd5},
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd6},
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd7},
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd7},  // R3 saturate at 7
    {1'b0, 2'b01, 2'b00, 3'd3, 1'b0, 3'd7},  // R4 hold
    {1'b0, 2'b11, 2'b00, 3'd0, 1'b0, 3'd6},  // R5 early hit
    {1'b0, 2'b11, 2'b00, 3'd7, 1'b0, 3'd5},  // R9 last-tick hit
    {1'b1, 2'b00, 2'b11, 3'd2, 1'b0, 3'd4},  // R8 high-line pair acts
    {1'b1, 2'b11, 2'b00, 3'd2, 1'b0, 3'd5},  // R8 low-line pair ignored
    {1'b0, 2'b00, 2'b11, 3'd5, 1'b0, 3'd6},  // R8 high-line pair ignored
    {1'b1, 2'b00, 2'b01, 3'd6, 1'b0, 3'd6},  // R4 hold, high-line set
    {1'b0, 2'b00, 2'b00, 3'd0, 1'b0, 3'd7},  // R9 no carry-over
    {1'b0, 2'b10, 2'b00, 3'd1, 1'b0, 3'd6},  // R5 above-high alone
    {1'b0, 2'b11, 2'b00, 3'd4, 1'b0, 3'd5},
    {1'b1, 2'b00, 2'b11, 3'd0, 1'b0, 3'd4},
    {1'b0, 2'b11, 2'b00, 3'd7, 1'b0, 3'd3},
    {1'b0, 2'b11, 2'b00, 3'd3, 1'b0, 3'd2},
    {1'b0, 2'b11, 2'b00, 3'd2, 1'b0, 3'd1},
    {1'b0, 2'b11, 2'b00, 3'd6, 1'b0, 3'd1}   // R5 saturate at 1
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: valleyTarget=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Give n ticks; the flag pair is shown only on tick position pos.
  task automatic run_ticks(input int n, input logic line, input logic [1:0] lo,
                           input logic [1:0] hi, input int pos);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn      = 1'b1;
      lineHigh    = line;
      flagsLoLine = (i == pos) ? lo : 2'b00;
      flagsHiLine = (i == pos) ? hi : 2'b00;
    end
    @(negedge clk);
    tickEn = 1'b0; flagsLoLine = '0; flagsHiLine = '0;
  endtask

  task automatic pulse_force(input int which);
    @(negedge clk);
    overReset  = (which == 0);
    startPulse = (which == 1);
    burstExit  = (which == 2);
    tickEn     = 1'b1;
    @(negedge clk);
    overReset = 1'b0; startPulse = 1'b0; burstExit = 1'b0; tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", valleyTarget, 3'd1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", valleyTarget, 3'd1);

    for (int r = 0; r < NROWS; r++) begin
      run_ticks(WIN, ROWS[r][11], ROWS[r][10:9], ROWS[r][8:7], int'(ROWS[r][6:4]));
      check($sformatf("R3/R4/R5/R8/R9 row %0d", r), valleyTarget, ROWS[r][2:0]);
    end

    // R2: one tick short of a window end leaves the target; idle cycles do not count.
    run_ticks(WIN - 1, 1'b0, 2'b00, 2'b00, 0);
    repeat (5) @(negedge clk);
    check("R2 mid-window stable", valleyTarget, 3'd1);
    run_ticks(1, 1'b0, 2'b00, 2'b00, 0);
    check("R2 window end step", valleyTarget, 3'd2);

    // R6: reset comparator mid-window forces 1 and restarts the window.
    run_ticks(WIN, 1'b0, 2'b00, 2'b00, 0);
    check("R6 setup", valleyTarget, 3'd3);
    run_ticks(3, 1'b0, 2'b00, 2'b00, 0);
    pulse_force(0);
    check("R6 force to 1", valleyTarget, 3'd1);
    run_ticks(WIN - 1, 1'b0, 2'b00, 2'b00, 0);
    check("R6 window restarted", valleyTarget, 3'd1);
    run_ticks(1, 1'b0, 2'b00, 2'b00, 0);
    check("R6 first full window", valleyTarget, 3'd2);

    // R6 without a tick in the force cycle.
    run_ticks(2, 1'b0, 2'b00, 2'b00, 0);
    @(negedge clk); overReset = 1'b1;
    @(negedge clk); overReset = 1'b0;
    check("R6 force without tick", valleyTarget, 3'd1);

    // R7: start-up pulse.
    run_ticks(WIN, 1'b0, 2'b00, 2'b00, 0);
    run_ticks(WIN, 1'b0, 2'b00, 2'b00, 0);
    check("R7 setup", valleyTarget, 3'd3);
    run_ticks(5, 1'b0, 2'b00, 2'b00, 0);
    pulse_force(1);
    check("R7 start pulse", valleyTarget, 3'd1);
    run_ticks(WIN, 1'b0, 2'b00, 2'b00, 0);
    check("R7 start restarts window", valleyTarget, 3'd2);

    // R7: burst-exit pulse.
    run_ticks(2, 1'b0, 2'b00, 2'b00, 0);
    pulse_force(2);
    check("R7 burst exit", valleyTarget, 3'd1);
    run_ticks(WIN, 1'b0, 2'b00, 2'b00, 0);
    check("R7 burst exit restarts window", valleyTarget, 3'd2);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule